// File: doc/BRIEF.md
# Configuration Space Register File

This block holds the 256-byte configuration header and device-specific area of one bus function. The space is little-endian: the byte at the lowest address carries the least significant bits of a word or dword. A host issues single requests carrying a byte address, a length code, write data and a write flag. Each byte has a fixed write mask that the block derives from its parameters, so software can only change the bits the mask allows. Read-only identity fields come out of reset from parameters.

Base address registers take their sizes from parameters at elaboration. Writing all ones to a BAR and reading it back tells software the window size. When a write changes any byte of the six BAR slots, or flips the I/O or memory decode enable in the command register, the block raises a one-cycle remap pulse. Address-decode logic elsewhere uses that pulse to rebuild its windows.

The request side is valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A read returns its data on a valid/ready response channel. While a response sits unaccepted (`rsp_valid` high, `rsp_ready` low), the data stays frozen and `req_ready` is held low, so no new request of either kind is taken. Writes return no response.

Top module: `cfg_space_regfile`

## Requirements
- R1: After reset the space holds these values:
  - Bytes 0x00–0x01: the vendor ID parameter.
  - Bytes 0x02–0x03: the device ID parameter.
  - Bytes 0x0A–0x0B: the 16-bit class parameter.
  - Low byte of each implemented BAR: its I/O type flag in bit 0.
  - Every other byte, the command register included: zero.
- R2: Write masks for the fixed bytes:
  - Command byte 0x04: only bits 0 (I/O enable), 1 (memory enable) and 2 (bus master) are writable.
  - Bytes 0x0C and 0x3C: fully writable.
  - Every byte from 0x40 to 0xFF: fully writable.
  - All other header bytes outside the BAR and ROM slots: read-only.
  - A written byte becomes (old & ~mask) | (new & mask).
- R3: BAR n sits at 0x10+4n. Its 32-bit write mask is ~(2^L−1), where L is its size log2. A BAR with L=0 is absent and always reads zero. Writing 0xFFFFFFFF reads back the mask OR'd with the type bit.
- R4: The expansion ROM BAR at 0x30 has mask ~(2^L−1) with bit 0 (enable) also writable.
- R5: Write length codes are 0 for one byte, 1 for two bytes and 2 for four bytes. Code 3 acts as four bytes. Byte k of the write data goes to address+k. Lanes past 0xFF are dropped and do not wrap to 0x00.
- R6: Read width follows the length code:
  - Four bytes are returned only for offsets ≤ 0xFC.
  - Otherwise two bytes are returned, but only for offsets ≤ 0xFE.
  - Otherwise one byte is returned.
  - A length code of 0 always returns one byte.
- R7: A read taken on edge t presents `rsp_valid` with data after edge t. Bytes beyond the served width read as zero. A write produces no response.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_rdata` is stable and `req_ready` is low.
- R9: `remap_pulse` is high for the cycle after a taken write that changed any byte in 0x10–0x27.
- R10: A write that toggles command bit 0 or 1 also pulses `remap_pulse`. No pulse follows any of these:
  - a write that changes only command bit 2;
  - a write that stores values equal to the old ones;
  - a write to the ROM BAR;
  - a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset in the space |
| req_len | input | 2 | Length code (0 byte, 1 word, 2/3 dword) |
| req_wdata | input | 32 | Write data, byte 0 at req_addr |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Read data taken |
| rsp_rdata | output | 32 | Read data, zero-extended to served width |
| remap_pulse | output | 1 | One-cycle pulse after a BAR or decode-enable change |

## Verification
The properties watch the handshake on every cycle:
- every taken read yields a response on the next cycle and every taken write yields none;
- a stalled response stays frozen and blocks new requests;
- a remap pulse never appears without a write taken just before it;
- narrow reads carry zeros above the served width.

Only the bench's scenarios can show whether the stored contents, the per-byte masks, the BAR size probes, the wrap-free lane drop and the exact conditions that raise or suppress the remap pulse are right. The bench compares those against a byte model of the space built from the requirements.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;
  localparam int unsigned SPACE_BYTES = 256;
  localparam int unsigned LANES       = 4;

  localparam logic [7:0] OFS_CMD     = 8'h04;
  localparam logic [7:0] OFS_LINESZ  = 8'h0C;
  localparam logic [7:0] OFS_BAR0    = 8'h10;
  localparam logic [7:0] OFS_BARLAST = 8'h27;
  localparam logic [7:0] OFS_ROM     = 8'h30;
  localparam logic [7:0] OFS_IRQLINE = 8'h3C;
  localparam logic [7:0] OFS_DEVSPEC = 8'h40;

  // Bytes touched by a write of the given length code.
  function automatic logic [2:0] wr_count(input logic [1:0] len);
    case (len)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // Bytes served by a read, narrowed near the top of the space.
  function automatic logic [2:0] rd_count(input logic [1:0] len, input logic [7:0] a);
    if (len[1] && a <= 8'hFC)       return 3'd4;
    else if (len != 2'd0 && a <= 8'hFE) return 3'd2;
    else                            return 3'd1;
  endfunction
endpackage

// File: rtl/cfgs_wmask.sv
module cfgs_wmask
  import cfgs_pkg::*;
#(
  parameter int unsigned          NUM_BAR  = 6,
  parameter logic [8*NUM_BAR-1:0] BAR_LOG2 = '0,
  parameter int unsigned          ROM_LOG2 = 0
) (
  input  logic [7:0] addr_i,
  output logic [7:0] mask_o
);
  localparam logic [31:0] ROM_MASK =
    (ROM_LOG2 == 0) ? 32'h0 : (~((32'h1 << ROM_LOG2) - 32'h1) | 32'h1);

  logic [31:0] bar_mask [NUM_BAR];

  for (genvar n = 0; n < NUM_BAR; n++) begin : g_bar
    localparam int unsigned L = int'(BAR_LOG2[8*n +: 8]);
    assign bar_mask[n] = (L == 0) ? 32'h0 : ~((32'h1 << L) - 32'h1);
  end

  always_comb begin
    mask_o = 8'h00;
    if (addr_i >= OFS_DEVSPEC)                         mask_o = 8'hFF;
    else if (addr_i == OFS_CMD)                        mask_o = 8'h07;
    else if (addr_i == OFS_LINESZ || addr_i == OFS_IRQLINE) mask_o = 8'hFF;
    else if (addr_i[7:2] == OFS_ROM[7:2])              mask_o = ROM_MASK[{addr_i[1:0], 3'b000} +: 8];
    else begin
      for (int n = 0; n < NUM_BAR; n++) begin
        if (addr_i[7:2] == 6'(int'(OFS_BAR0[7:2]) + n))
          mask_o = bar_mask[n][{addr_i[1:0], 3'b000} +: 8];
      end
    end
  end
endmodule

// File: rtl/cfgs_store.sv
module cfgs_store
  import cfgs_pkg::*;
#(
  parameter int unsigned          NUM_BAR    = 6,
  parameter logic [8*NUM_BAR-1:0] BAR_LOG2   = '0,
  parameter logic [NUM_BAR-1:0]   BAR_IS_IO  = '0,
  parameter logic [15:0]          VENDOR_ID  = 16'h0,
  parameter logic [15:0]          DEVICE_ID  = 16'h0,
  parameter logic [15:0]          CLASS_CODE = 16'h0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lane_we   [LANES],
  input  logic [7:0] lane_addr [LANES],
  input  logic [7:0] lane_data [LANES],
  output logic [7:0] byte_q    [SPACE_BYTES]
);
  function automatic logic [7:0] init_byte(input int unsigned a);
    logic [7:0] v;
    v = 8'h00;
    case (a)
      0:  v = VENDOR_ID[7:0];
      1:  v = VENDOR_ID[15:8];
      2:  v = DEVICE_ID[7:0];
      3:  v = DEVICE_ID[15:8];
      10: v = CLASS_CODE[7:0];
      11: v = CLASS_CODE[15:8];
      default: v = 8'h00;
    endcase
    for (int n = 0; n < NUM_BAR; n++)
      if (a == 16 + 4*n && BAR_LOG2[8*n +: 8] != 8'd0)
        v = {7'b0, BAR_IS_IO[n]};
    return v;
  endfunction

  for (genvar i = 0; i < SPACE_BYTES; i++) begin : g_byte
    localparam logic [7:0] INIT = init_byte(i);
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) q <= INIT;
      else begin
        for (int k = 0; k < LANES; k++)
          if (lane_we[k] && lane_addr[k] == 8'(i)) q <= lane_data[k];
      end
    end
    assign byte_q[i] = q;
  end
endmodule

// File: rtl/cfgs_remap.sv
module cfgs_remap
  import cfgs_pkg::*;
(
  input  logic       lane_we   [LANES],
  input  logic [7:0] lane_addr [LANES],
  input  logic [7:0] lane_old  [LANES],
  input  logic [7:0] lane_new  [LANES],
  output logic       hit_o
);
  always_comb begin
    hit_o = 1'b0;
    for (int k = 0; k < LANES; k++) begin
      if (lane_we[k]) begin
        if (lane_addr[k] >= OFS_BAR0 && lane_addr[k] <= OFS_BARLAST &&
            lane_old[k] != lane_new[k])
          hit_o = 1'b1;
        if (lane_addr[k] == OFS_CMD && (lane_old[k][1:0] != lane_new[k][1:0]))
          hit_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfg_space_regfile.sv
module cfg_space_regfile
  import cfgs_pkg::*;
#(
  parameter int unsigned          NUM_BAR    = 6,
  parameter logic [8*NUM_BAR-1:0] BAR_LOG2   = {8'd0, 8'd0, 8'd20, 8'd0, 8'd4, 8'd12},
  parameter logic [NUM_BAR-1:0]   BAR_IS_IO  = 6'b000010,
  parameter int unsigned          ROM_LOG2   = 16,
  parameter logic [15:0]          VENDOR_ID  = 16'h1D0F,
  parameter logic [15:0]          DEVICE_ID  = 16'h7A11,
  parameter logic [15:0]          CLASS_CODE = 16'h0580
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [7:0]  req_addr,
  input  logic [1:0]  req_len,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_rdata,
  output logic        remap_pulse
);
  logic [7:0] cfg_q [SPACE_BYTES];
  logic       accept;
  logic [2:0] wr_n, rd_n;
  logic       lane_we   [LANES];
  logic [7:0] lane_addr [LANES];
  logic [7:0] lane_mask [LANES];
  logic [7:0] lane_old  [LANES];
  logic [7:0] lane_new  [LANES];
  logic [7:0] rd_byte   [LANES];
  logic       remap_hit;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_n      = wr_count(req_len);
  assign rd_n      = rd_count(req_len, req_addr);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [8:0] a9;
    assign a9           = {1'b0, req_addr} + 9'(k);
    assign lane_addr[k] = a9[7:0];
    assign lane_we[k]   = accept && req_write && (3'(k) < wr_n) && !a9[8];

    cfgs_wmask #(
      .NUM_BAR (NUM_BAR),
      .BAR_LOG2(BAR_LOG2),
      .ROM_LOG2(ROM_LOG2)
    ) u_mask (
      .addr_i(lane_addr[k]),
      .mask_o(lane_mask[k])
    );

    assign lane_old[k] = cfg_q[lane_addr[k]];
    assign lane_new[k] = (lane_old[k] & ~lane_mask[k]) | (req_wdata[8*k +: 8] & lane_mask[k]);
    assign rd_byte[k]  = (3'(k) < rd_n) ? lane_old[k] : 8'h00;
  end

  cfgs_store #(
    .NUM_BAR   (NUM_BAR),
    .BAR_LOG2  (BAR_LOG2),
    .BAR_IS_IO (BAR_IS_IO),
    .VENDOR_ID (VENDOR_ID),
    .DEVICE_ID (DEVICE_ID),
    .CLASS_CODE(CLASS_CODE)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .lane_we  (lane_we),
    .lane_addr(lane_addr),
    .lane_data(lane_new),
    .byte_q   (cfg_q)
  );

  cfgs_remap u_remap (
    .lane_we  (lane_we),
    .lane_addr(lane_addr),
    .lane_old (lane_old),
    .lane_new (lane_new),
    .hit_o    (remap_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_rdata   <= 32'h0;
      remap_pulse <= 1'b0;
    end else begin
      remap_pulse <= remap_hit;
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      if (accept && !req_write) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= {rd_byte[3], rd_byte[2], rd_byte[1], rd_byte[0]};
      end
    end
  end
endmodule

// File: rtl/cfgs_chk.sv
module cfgs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic [7:0]  req_addr,
  input logic [1:0]  req_len,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_rdata,
  input logic        remap_pulse
);
  logic rd_take, wr_take;
  assign rd_take = req_valid && req_ready && !req_write;
  assign wr_take = req_valid && req_ready && req_write;

  // R7
  read_gives_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_take |=> rsp_valid);

  // R7
  write_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |=> !rsp_valid);

  // R7
  byte_read_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_take && req_len == 2'd0) |=> rsp_rdata[31:8] == 24'h0);

  // R6
  dword_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_take && req_len[1] && req_addr > 8'hFC) |=> rsp_rdata[31:16] == 16'h0);

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R8
  stall_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R9
  remap_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    remap_pulse |-> $past(wr_take));
endmodule

bind cfg_space_regfile cfgs_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .req_len    (req_len),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_rdata  (rsp_rdata),
  .remap_pulse(remap_pulse)
);

// File: tb/cfg_space_regfile_test.sv
`timescale 1ns/1ps
module cfg_space_regfile_test;
  localparam logic [47:0] BL   = {8'd0, 8'd0, 8'd20, 8'd0, 8'd4, 8'd12};
  localparam logic [5:0]  BIO  = 6'b000010;
  localparam int          ROML = 16;
  localparam logic [15:0] VID  = 16'h1D0F;
  localparam logic [15:0] DID  = 16'h7A11;
  localparam logic [15:0] CLS  = 16'h0580;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [7:0] req_addr = 8'h0;
  logic [1:0] req_len = 2'd0;
  logic [31:0] req_wdata = 32'h0;
  logic req_ready, rsp_valid, remap_pulse;
  logic [31:0] rsp_rdata;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] m [256];

  always #4 clk = ~clk;

  cfg_space_regfile #(
    .NUM_BAR(6), .BAR_LOG2(BL), .BAR_IS_IO(BIO), .ROM_LOG2(ROML),
    .VENDOR_ID(VID), .DEVICE_ID(DID), .CLASS_CODE(CLS)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .remap_pulse(remap_pulse)
  );

  function automatic logic [31:0] size_mask(input int l);
    if (l == 0) return 32'h0;
    return ~((32'h1 << l) - 32'h1);
  endfunction

  // Expected per-byte mask (R2, R3, R4).
  function automatic logic [7:0] bmask(input int a);
    logic [31:0] w;
    if (a >= 8'h40) return 8'hFF;
    if (a == 8'h04) return 8'h07;
    if (a == 8'h0C || a == 8'h3C) return 8'hFF;
    if (a >= 8'h30 && a <= 8'h33) begin
      w = size_mask(ROML) | 32'h1;
      return w[8*(a-8'h30) +: 8];
    end
    if (a >= 8'h10 && a <= 8'h27) begin
      w = size_mask(int'(BL[8*((a-16)/4) +: 8]));
      return w[8*(a%4) +: 8];
    end
    return 8'h00;
  endfunction

  // Expected reset contents (R1).
  function automatic logic [7:0] binit(input int a);
    case (a)
      0: return VID[7:0];
      1: return VID[15:8];
      2: return DID[7:0];
      3: return DID[15:8];
      10: return CLS[7:0];
      11: return CLS[15:8];
      default: ;
    endcase
    if (a >= 16 && a <= 39 && a % 4 == 0 && BL[8*((a-16)/4) +: 8] != 0)
      return {7'b0, BIO[(a-16)/4]};
    return 8'h00;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [1:0] len, input logic [31:0] d, input string tag);
    int nb;
    bit exp_remap;
    logic [7:0] o, nw, mk;
    nb = (len == 0) ? 1 : (len == 1) ? 2 : 4;
    exp_remap = 1'b0;
    for (int k = 0; k < nb; k++) begin
      int ad;
      ad = int'(a) + k;
      if (ad <= 255) begin
        o  = m[ad];
        mk = bmask(ad);
        nw = (o & ~mk) | (d[8*k +: 8] & mk);
        if (ad >= 16 && ad <= 39 && nw != o) exp_remap = 1'b1;
        if (ad == 4 && nw[1:0] != o[1:0]) exp_remap = 1'b1;
        m[ad] = nw;
      end
    end
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_len = len; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk(remap_pulse === exp_remap && rsp_valid === 1'b0, {tag, " remap"},
        {30'b0, rsp_valid, remap_pulse}, {31'b0, exp_remap});
  endtask

  function automatic logic [31:0] exp_read(input logic [7:0] a, input logic [1:0] len);
    int nb;
    logic [31:0] v;
    if (len[1] && a <= 8'hFC) nb = 4;
    else if (len != 0 && a <= 8'hFE) nb = 2;
    else nb = 1;
    v = 32'h0;
    for (int k = 0; k < nb; k++) v[8*k +: 8] = m[int'(a) + k];
    return v;
  endfunction

  task automatic rd(input logic [7:0] a, input logic [1:0] len, input string tag);
    logic [31:0] e;
    e = exp_read(a, len);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_len = len;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid === 1'b1 && rsp_rdata === e, tag, rsp_rdata, e);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] held;
    int unsigned seed;
    seed = $urandom(32'd4242);
    for (int i = 0; i < 256; i++) m[i] = binit(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid === 1'b0 && remap_pulse === 1'b0 && req_ready === 1'b1,
        "R1 reset outputs", {29'b0, rsp_valid, remap_pulse, req_ready}, 32'h1);

    // R1 reset contents
    rd(8'h00, 2'd2, "R1 vendor/device");
    rd(8'h08, 2'd2, "R1 class");
    rd(8'h04, 2'd2, "R1 command clear");
    rd(8'h14, 2'd2, "R1 io bar type");
    rd(8'h10, 2'd2, "R1 mem bar type");

    // R2 command mask and R10 toggle rules
    wr(8'h04, 2'd2, 32'hFFFF_FFFF, "R10 cmd enables on");
    rd(8'h04, 2'd2, "R2 command mask");
    wr(8'h04, 2'd0, 32'h04, "R10 cmd io/mem off");
    wr(8'h04, 2'd0, 32'h04, "R10 cmd same value");
    wr(8'h04, 2'd0, 32'h00, "R10 cmd master only");
    rd(8'h04, 2'd0, "R2 command readback");
    wr(8'h0C, 2'd0, 32'hA5, "R2 line size");
    wr(8'h3C, 2'd1, 32'h5A5A, "R2 irq line");
    rd(8'h3C, 2'd1, "R2 irq line/pin");
    wr(8'h08, 2'd2, 32'hFFFF_FFFF, "R2 class read-only");
    rd(8'h08, 2'd2, "R2 class unchanged");
    wr(8'h00, 2'd2, 32'h1234_5678, "R2 id read-only");
    rd(8'h00, 2'd2, "R2 id unchanged");
    wr(8'h40, 2'd2, 32'hDEAD_BEEF, "R2 devspec");
    rd(8'h40, 2'd2, "R2 devspec readback");

    // R3 BAR size probing, R9 remap
    wr(8'h10, 2'd2, 32'hFFFF_FFFF, "R9 bar0 probe");
    rd(8'h10, 2'd2, "R3 bar0 size");
    wr(8'h14, 2'd2, 32'hFFFF_FFFF, "R9 bar1 probe");
    rd(8'h14, 2'd2, "R3 bar1 io size");
    wr(8'h18, 2'd2, 32'hFFFF_FFFF, "R9 absent bar no change");
    rd(8'h18, 2'd2, "R3 absent bar zero");
    wr(8'h1C, 2'd2, 32'hFFFF_FFFF, "R9 bar3 probe");
    rd(8'h1C, 2'd2, "R3 bar3 size");
    wr(8'h10, 2'd2, 32'hFFFF_F000, "R9 bar0 same value");
    wr(8'h12, 2'd1, 32'h0000, "R9 bar0 upper word");
    rd(8'h10, 2'd2, "R3 bar0 after word");

    // R4 ROM BAR
    wr(8'h30, 2'd2, 32'hFFFF_FFFF, "R10 rom no remap");
    rd(8'h30, 2'd2, "R4 rom size+enable");
    wr(8'h30, 2'd0, 32'h00, "R4 rom enable clear");
    rd(8'h30, 2'd2, "R4 rom after clear");

    // R5 lengths, lane drop at top, code 3
    wr(8'hFE, 2'd2, 32'h1122_3344, "R5 dword at FE");
    rd(8'hFE, 2'd1, "R5 top bytes");
    rd(8'h00, 2'd1, "R5 no wrap");
    wr(8'h80, 2'd3, 32'hCAFE_F00D, "R5 code 3");
    rd(8'h80, 2'd2, "R5 code 3 readback");
    wr(8'h90, 2'd1, 32'hFFFF_ABCD, "R5 word write");
    rd(8'h90, 2'd2, "R5 word lanes only");

    // R6 read fallback
    rd(8'hFD, 2'd2, "R6 dword at FD");
    rd(8'hFF, 2'd2, "R6 dword at FF");
    rd(8'hFF, 2'd1, "R6 word at FF");
    rd(8'h91, 2'd0, "R6 byte read");

    // R8 stall
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h80; req_len = 2'd2;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h80; req_wdata = 32'h0;
    held = rsp_rdata;
    chk(req_ready === 1'b0, "R8 ready low in stall", {31'b0, req_ready}, 32'h0);
    repeat (3) @(negedge clk);
    chk(rsp_valid === 1'b1 && rsp_rdata === held, "R8 rsp held", rsp_rdata, held);
    req_valid = 1'b0; req_write = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R8 rsp drained", {31'b0, rsp_valid}, 32'h0);
    rd(8'h80, 2'd2, "R8 stalled write dropped");

    // R7 and mixed random traffic
    for (int i = 0; i < 500; i++) begin
      logic [7:0] a;
      logic [1:0] l;
      logic [31:0] d;
      a = 8'($urandom);
      if ($urandom % 3 == 0) a = 8'h04 + 8'($urandom % 48);
      l = 2'($urandom);
      d = $urandom;
      if ($urandom % 2 == 0) wr(a, l, d, "R9 random write");
      else rd(a, l, "R7 random read");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule